// File: doc/BRIEF.md
# I2C High-Speed and Stop-Event Monitor

This block watches the synchronized SDA and SCL lines next to an I2C target engine. It finds START, repeated START and STOP conditions, and after each START it captures the first byte on the bus together with its acknowledge bit. When that byte is a host code and it is not acknowledged, the block switches into high-speed operation by itself and raises a status bit. That bit holds until a STOP is seen. Automatic switching only takes place when the speed setting selects high-speed and the target stretches the clock only after the acknowledge bit.

The block also produces the one-cycle pulse that sets the target's stop interrupt flag. The target engine reports address matches on `addr_match`. A STOP raises the pulse when this target was addressed at any point since the previous STOP. It also raises the pulse on every STOP when group-command handling is enabled and 7-bit addressing is in use, so a target addressed in the middle of a group transfer learns when the shared STOP arrives.

There are no data streams, so no valid/ready interface is used. All pins are plain level or pulse signals, sampled on the rising edge of `clk`.

Top module: `i2c_hs_stop_monitor`

## Requirements
- R1: Automatic high-speed entry happens only while `speed_sel` equals 2'b10 and `stretch_after_ack` is 1. With any other speed code, or with `stretch_after_ack` at 0, a NACKed host code leaves `hs_active` at 0.
- R2: The first byte after a START or a repeated START is shifted in MSB first on eight SCL rising edges. SDA at the ninth SCL rising edge is the acknowledge bit, where 1 means NACK. If that byte matches 00001xxx and is NACKed, `hs_active` becomes 1. An acknowledged host code, any other byte pattern, and any later byte of the same transfer leave it unchanged.
- R3: A STOP (SDA rising while SCL is high) clears `hs_active` in the cycle after it is sampled.
- R4: With `group_cmd_en`=1 and `ten_bit_mode`=0, every STOP produces a `stop_flag_set` pulse, whether or not `addr_match` was seen.
- R5: With `group_cmd_en`=0, a STOP produces a `stop_flag_set` pulse only if `addr_match` was 1 in at least one cycle since the previous STOP or reset. The STOP also clears that record.
- R6: `stop_flag_set` is high for exactly one cycle: the cycle after the clock edge at which the STOP is sampled.
- R7: A repeated START (SDA falling while SCL is high, with no STOP in between) does not clear `hs_active`.
- R8: While `rst_n` is 0, `hs_active` and `stop_flag_set` are 0, and the address-match record is cleared.
- R9: With `group_cmd_en`=1 and `ten_bit_mode`=1, a STOP follows the rule of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sda_i | input | 1 | Synchronized SDA level |
| scl_i | input | 1 | Synchronized SCL level |
| speed_sel | input | 2 | Speed setting; 2'b10 selects high-speed |
| stretch_after_ack | input | 1 | 1 when the target stretches SCL only after the ACK bit |
| ten_bit_mode | input | 1 | 1 when the target uses 10-bit addressing |
| addr_match | input | 1 | Address-match pulse from the target engine |
| group_cmd_en | input | 1 | Enables a stop pulse on every bus STOP |
| hs_active | output | 1 | High-speed status bit |
| stop_flag_set | output | 1 | One-cycle pulse that sets the stop interrupt flag |

## Verification
The hardest state to reach from the ports is high-speed entry. It needs a START, exactly eight data edges carrying the host-code prefix, and SDA held high at the ninth SCL rise, with the lines moving only while SCL is low except at the conditions themselves. The bench builds every transfer from bit-level tasks that move SDA only during SCL low. Each table row runs a whole frame from START to STOP. Directed tests then place a repeated START inside high-speed operation, put the host code in the second byte, and apply reset in the middle of a transfer.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } bus_evt_t;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
  import i2c_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sda_i,
  input  logic     scl_i,
  output bus_evt_t evt
);
  logic sda_q, scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
    end
  end

  // Conditions are judged with SCL high in both the old and the new sample.
  always_comb begin
    evt.start    = scl_i & scl_q & sda_q & ~sda_i;
    evt.stop     = scl_i & scl_q & ~sda_q & sda_i;
    evt.scl_rise = scl_i & ~scl_q;
  end
endmodule

// File: rtl/i2c_first_byte_capture.sv
module i2c_first_byte_capture
  import i2c_mon_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int PREFIX_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bus_evt_t            evt,
  input  logic                sda_i,
  output logic                byte_done,
  output logic                ack_nack,
  output logic [PREFIX_W-1:0] hdr_bits
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      armed     <= 1'b0;
      byte_done <= 1'b0;
      ack_nack  <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (evt.stop) begin
        armed <= 1'b0;
      end else if (evt.start) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && evt.scl_rise) begin
        if (cnt == CNT_W'(BYTE_W)) begin
          ack_nack  <= sda_i;
          byte_done <= 1'b1;
          armed     <= 1'b0;
        end else begin
          shreg <= {shreg[BYTE_W-2:0], sda_i};
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  assign hdr_bits = shreg[BYTE_W-1 -: PREFIX_W];
endmodule

// File: rtl/i2c_hs_tracker.sv
module i2c_hs_tracker #(
  parameter int                PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] HOST_PREFIX = 5'b00001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                auto_en,
  input  logic                bus_stop,
  input  logic                byte_done,
  input  logic                ack_nack,
  input  logic [PREFIX_W-1:0] hdr_bits,
  output logic                hs_active
);
  logic is_host_code;
  assign is_host_code = (hdr_bits == HOST_PREFIX);

  always_ff @(posedge clk) begin
    if (!rst_n)
      hs_active <= 1'b0;
    else if (bus_stop)
      hs_active <= 1'b0;
    else if (byte_done && ack_nack && is_host_code && auto_en)
      hs_active <= 1'b1;
  end
endmodule

// File: rtl/i2c_stop_flagger.sv
module i2c_stop_flagger (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_stop,
  input  logic addr_match,
  input  logic group_cmd_en,
  input  logic ten_bit_mode,
  output logic stop_flag_set
);
  logic addressed;
  logic group_any;

  assign group_any = group_cmd_en & ~ten_bit_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addressed     <= 1'b0;
      stop_flag_set <= 1'b0;
    end else begin
      stop_flag_set <= bus_stop & (addressed | addr_match | group_any);
      if (bus_stop)
        addressed <= 1'b0;
      else if (addr_match)
        addressed <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_hs_stop_monitor.sv
module i2c_hs_stop_monitor
  import i2c_mon_pkg::*;
#(
  parameter int                  BYTE_W      = 8,
  parameter int                  SPEED_W     = 2,
  parameter logic [SPEED_W-1:0]  SPEED_HS    = 2'b10,
  parameter int                  PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] HOST_PREFIX = 5'b00001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_i,
  input  logic               scl_i,
  input  logic [SPEED_W-1:0] speed_sel,
  input  logic               stretch_after_ack,
  input  logic               ten_bit_mode,
  input  logic               addr_match,
  input  logic               group_cmd_en,
  output logic               hs_active,
  output logic               stop_flag_set
);
  bus_evt_t            evt;
  logic                byte_done;
  logic                ack_nack;
  logic [PREFIX_W-1:0] hdr_bits;
  logic                auto_en;

  assign auto_en = (speed_sel == SPEED_HS) & stretch_after_ack;

  i2c_bus_events u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .sda_i (sda_i),
    .scl_i (scl_i),
    .evt   (evt)
  );

  i2c_first_byte_capture #(
    .BYTE_W   (BYTE_W),
    .PREFIX_W (PREFIX_W)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .sda_i     (sda_i),
    .byte_done (byte_done),
    .ack_nack  (ack_nack),
    .hdr_bits  (hdr_bits)
  );

  i2c_hs_tracker #(
    .PREFIX_W    (PREFIX_W),
    .HOST_PREFIX (HOST_PREFIX)
  ) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_en   (auto_en),
    .bus_stop  (evt.stop),
    .byte_done (byte_done),
    .ack_nack  (ack_nack),
    .hdr_bits  (hdr_bits),
    .hs_active (hs_active)
  );

  i2c_stop_flagger u_stop (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_stop      (evt.stop),
    .addr_match    (addr_match),
    .group_cmd_en  (group_cmd_en),
    .ten_bit_mode  (ten_bit_mode),
    .stop_flag_set (stop_flag_set)
  );
endmodule

// File: rtl/i2c_hs_stop_monitor_chk.sv
module i2c_hs_stop_monitor_chk #(
  parameter int                 SPEED_W  = 2,
  parameter logic [SPEED_W-1:0] SPEED_HS = 2'b10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sda_i,
  input logic               scl_i,
  input logic [SPEED_W-1:0] speed_sel,
  input logic               stretch_after_ack,
  input logic               ten_bit_mode,
  input logic               group_cmd_en,
  input logic               hs_active,
  input logic               stop_flag_set
);
  logic sda_d, scl_d, stop_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_d <= 1'b1;
      scl_d <= 1'b1;
    end else begin
      sda_d <= sda_i;
      scl_d <= scl_i;
    end
  end

  assign stop_now = scl_i & scl_d & sda_i & ~sda_d;

  AST_HS_NEEDS_AUTO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_active) |-> $past(speed_sel == SPEED_HS && stretch_after_ack)); // R1
  AST_HS_DROPS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> !hs_active); // R3
  AST_GROUP_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_now && group_cmd_en && !ten_bit_mode) |=> stop_flag_set); // R4
  AST_PULSE_FOLLOWS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag_set |-> $past(stop_now)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag_set |=> !stop_flag_set); // R6
  AST_HS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_active && !stop_now) |=> hs_active); // R7
endmodule

bind i2c_hs_stop_monitor i2c_hs_stop_monitor_chk #(
  .SPEED_W  (SPEED_W),
  .SPEED_HS (SPEED_HS)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .sda_i             (sda_i),
  .scl_i             (scl_i),
  .speed_sel         (speed_sel),
  .stretch_after_ack (stretch_after_ack),
  .ten_bit_mode      (ten_bit_mode),
  .group_cmd_en      (group_cmd_en),
  .hs_active         (hs_active),
  .stop_flag_set     (stop_flag_set)
);

// File: tb/i2c_hs_stop_monitor_bench.sv
module i2c_hs_stop_monitor_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] spd;
    logic       st;
    logic       gc;
    logic       tb;
    logic       am;
    logic [7:0] b;
    logic       nk;
    logic       ehs;
    logic       estop;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h09, 1'b1, 1'b1, 1'b0}, // R2 host code NACK
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h09, 1'b1, 1'b0, 1'b0}, // R1 no stretch mode
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0C, 1'b1, 1'b0, 1'b0}, // R1 wrong speed
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b0}, // R2 ACKed
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h19, 1'b1, 1'b0, 1'b0}, // R2 wrong pattern
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h08, 1'b1, 1'b1, 1'b1}, // R4 group 7-bit
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA4, 1'b0, 1'b0, 1'b1}, // R5 addressed
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hF2, 1'b0, 1'b0, 1'b0}, // R9 10-bit no match
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hF2, 1'b0, 1'b0, 1'b1}, // R9 10-bit match
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0A, 1'b1, 1'b1, 1'b0}  // R5 not addressed
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sda = 1'b1;
  logic       scl = 1'b1;
  logic [1:0] speed_sel = 2'd0;
  logic       stretch_after_ack = 1'b0;
  logic       ten_bit_mode = 1'b0;
  logic       addr_match = 1'b0;
  logic       group_cmd_en = 1'b0;
  logic       hs_active, stop_flag_set;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_hs_stop_monitor u_i2c_hs_stop_monitor (
    .clk               (clk),
    .rst_n             (rst_n),
    .sda_i             (sda),
    .scl_i             (scl),
    .speed_sel         (speed_sel),
    .stretch_after_ack (stretch_after_ack),
    .ten_bit_mode      (ten_bit_mode),
    .addr_match        (addr_match),
    .group_cmd_en      (group_cmd_en),
    .hs_active         (hs_active),
    .stop_flag_set     (stop_flag_set)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 1'b0; waitn(1);
    sda = 1'b1; waitn(1);
    scl = 1'b1; waitn(2);
    sda = 1'b0; waitn(2);
    scl = 1'b0; waitn(1);
  endtask

  task automatic bus_bit(input logic b);
    sda = b;    waitn(2);
    scl = 1'b1; waitn(2);
    scl = 1'b0; waitn(1);
  endtask

  task automatic bus_byte(input logic [7:0] b, input logic nk);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    bus_bit(nk);
    waitn(2);
  endtask

  task automatic pulse_match();
    addr_match = 1'b1; waitn(1);
    addr_match = 1'b0; waitn(1);
  endtask

  // Drives a STOP and checks the pulse one edge later and its absence after.
  task automatic bus_stop_chk(input string req, input logic exp_pulse);
    scl = 1'b0; waitn(1);
    sda = 1'b0; waitn(1);
    scl = 1'b1; waitn(2);
    sda = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(req, stop_flag_set, exp_pulse);
    chk("R3 hs cleared by STOP", hs_active, 1'b0);
    waitn(1);
    chk("R6 pulse lasts one cycle", stop_flag_set, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitn(3);
    chk("R8 hs_active in reset", hs_active, 1'b0);
    chk("R8 stop_flag_set in reset", stop_flag_set, 1'b0);
    rst_n = 1'b1;
    waitn(2);

    for (int v = 0; v < NV; v++) begin
      speed_sel         = VECS[v].spd;
      stretch_after_ack = VECS[v].st;
      group_cmd_en      = VECS[v].gc;
      ten_bit_mode      = VECS[v].tb;
      bus_start();
      bus_byte(VECS[v].b, VECS[v].nk);
      if (VECS[v].am) pulse_match();
      chk($sformatf("R1/R2 vector %0d hs_active", v), hs_active, VECS[v].ehs);
      bus_stop_chk($sformatf("R4/R5/R9 vector %0d stop pulse", v), VECS[v].estop);
    end

    // R7: repeated START in high-speed mode keeps the status bit
    speed_sel = 2'd2; stretch_after_ack = 1'b1; group_cmd_en = 1'b0; ten_bit_mode = 1'b0;
    bus_start();
    bus_byte(8'h0B, 1'b1);
    chk("R2 enter hs", hs_active, 1'b1);
    bus_start();
    chk("R7 hs after repeated START", hs_active, 1'b1);
    bus_byte(8'h55, 1'b0);
    chk("R7 hs after byte following repeated START", hs_active, 1'b1);
    bus_stop_chk("R5 no match no pulse", 1'b0);

    // R2: host code as second byte of a transfer is ignored
    bus_start();
    bus_byte(8'h20, 1'b0);
    bus_byte(8'h09, 1'b1);
    chk("R2 host code in second byte ignored", hs_active, 1'b0);
    bus_stop_chk("R5 no match no pulse", 1'b0);

    // R5: the match record is cleared by a STOP
    bus_start();
    pulse_match();
    bus_stop_chk("R5 matched transfer pulses", 1'b1);
    bus_start();
    bus_stop_chk("R5 record cleared by previous STOP", 1'b0);

    // R8: reset in mid-transfer clears hs and the match record
    bus_start();
    bus_byte(8'h0E, 1'b1);
    pulse_match();
    chk("R2 enter hs before reset", hs_active, 1'b1);
    rst_n = 1'b0; waitn(2);
    chk("R8 hs cleared by reset", hs_active, 1'b0);
    rst_n = 1'b1; waitn(2);
    bus_stop_chk("R8 match record cleared by reset", 1'b0);

    // R4: group mode pulses on a bare START/STOP
    group_cmd_en = 1'b1;
    bus_start();
    bus_stop_chk("R4 group STOP without match", 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule